// File: doc/BRIEF.md
# Bit-Serial Microprogram Sequencer

This block is the control unit in front of a row-parallel compute array that works on data stored vertically, one bit of every element per row. Software hands it bulk instructions. Each instruction holds an opcode, a destination row base, two source row bases and an element width `n`. The instructions wait in an in-order queue. For the instruction at the head of the queue, the sequencer reads the microprogram for its opcode from a built-in microprogram memory. It then walks a program counter through that microprogram. Every copy micro-op becomes a command triplet, activate-activate-precharge. Every compute micro-op becomes a command pair, activate-precharge. A loop micro-op sends the program counter back to the start of the body, and the loop runs once for each bit of the operands.

Source and destination row addresses are the row base plus the current bit index, so pass `i` touches bit row `i` of each operand. The compute rows and the constant-zero row sit at fixed addresses starting at `TROW_BASE`. Commands leave one per cycle over a valid/ready port to the array. Each retired instruction raises a one-cycle completion pulse.

States and transitions of the controller:
- IDLE → FETCH when the queue holds an instruction with `n > 0`. On this transition the loop counter is loaded with `n`, and the bit index and program counter are cleared.
- IDLE → RETIRE when the head instruction has `n = 0`.
- FETCH → ACT_A on a copy or compute micro-op.
- FETCH → FETCH on a loop micro-op. The counter is decremented. If it was not 1, the program counter jumps to the micro-op's target and the bit index increments. Otherwise the program counter increments.
- FETCH → RETIRE on a done micro-op.
- ACT_A → ACT_B (copy) or ACT_A → PRE (compute) when the command is taken.
- ACT_B → PRE when the command is taken.
- PRE → FETCH when the command is taken. The program counter increments.
- RETIRE → IDLE. This pops the queue and pulses `op_done`.

Top module: `bitserial_seq`

## Requirements
- R1: An instruction is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while `DEPTH` accepted instructions have not yet retired. Instructions execute in the order they were accepted.
- R2: A copy micro-op emits three commands in order: ACT of its first row, ACT of its second row, then PRE. `cmd_kind` encodes ACT as 0 and PRE as 1, and `cmd_row` is 0 during a PRE.
- R3: A compute micro-op emits ACT of its row followed by PRE. No more than two ACTs are ever accepted without a PRE between them.
- R4: Source and destination rows are `base + i` modulo 2^`ROWW`, where `i` is the bit index. The fixed rows are T0=`TROW_BASE`, T1=+1, T2=+2, the triple-activate row=+3 and the zero row=+4.
- R5: The loop body executes exactly `n` times, with bit index 0, 1, …, n-1, and every one of its commands is issued.
- R6: Microprograms per opcode, with S1/S2/D meaning the source and destination rows at the current bit:
  - Opcode 0: copy S1→D.
  - Opcode 1: copy S1→T0, S2→T1, zero→T2, triple→D.
  - Opcode 2: copy S1→T0, S2→T1, D→T2; compute on triple; copy T0→D.
  - Opcode 3: copy zero→D.
- R7: An instruction with `n = 0` issues no command and still retires with an `op_done` pulse.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_kind` and `cmd_row` hold their values.
- R9: `op_done` is a single-cycle pulse, one per instruction, raised only after every command of that instruction has been accepted and never in the same cycle as `cmd_valid`.
- R10: After reset `cmd_valid` and `op_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Queue has room |
| in_op | input | OPW | Opcode |
| in_dst | input | ROWW | Destination row base |
| in_src1 | input | ROWW | First source row base |
| in_src2 | input | ROWW | Second source row base |
| in_n | input | NW | Element width in bits |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Array takes the command |
| cmd_kind | output | 1 | 0 = ACT, 1 = PRE |
| cmd_row | output | ROWW | Row address for ACT |
| op_done | output | 1 | Instruction retired |

## Verification
A wrong program counter or microprogram entry shows up at the command port as an out-of-order row or a wrong command kind. It appears at the first command issued after the fault. A bit index or loop counter that is off by one shows as a wrong row in the second pass, or as a pass that is missing or added. The bench detects the missing or added pass when `op_done` arrives at the wrong command count. A queue occupancy error shows as an `in_ready` value that differs from the count of accepted but unretired instructions in the same cycle.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int UPC_W = 6;

    typedef enum logic [1:0] {
        UOP_AAP  = 2'd0,
        UOP_AP   = 2'd1,
        UOP_LOOP = 2'd2,
        UOP_DONE = 2'd3
    } uop_kind_e;

    typedef enum logic [2:0] {
        RS_SRC1   = 3'd0,
        RS_SRC2   = 3'd1,
        RS_DST    = 3'd2,
        RS_T0     = 3'd3,
        RS_T1     = 3'd4,
        RS_T2     = 3'd5,
        RS_TRIPLE = 3'd6,
        RS_ZERO   = 3'd7
    } row_sel_e;

    typedef struct packed {
        uop_kind_e        kind;
        row_sel_e         sel_a;
        row_sel_e         sel_b;
        logic [UPC_W-1:0] target;
    } uop_t;

    typedef enum logic {
        CMD_ACT = 1'b0,
        CMD_PRE = 1'b1
    } cmd_kind_e;

    function automatic uop_t mk_uop(uop_kind_e k, row_sel_e a, row_sel_e b,
                                    logic [UPC_W-1:0] t);
        uop_t u;
        u.kind   = k;
        u.sel_a  = a;
        u.sel_b  = b;
        u.target = t;
        return u;
    endfunction

endpackage

// File: rtl/bsq_fifo.sv
module bsq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign dout  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push && !full) wr_q <= bump(wr_q);
            if (pop && !empty) rd_q <= bump(rd_q);
            unique case ({push && !full, pop && !empty})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/bsq_uprog_rom.sv
module bsq_uprog_rom
    import bsq_pkg::*;
#(
    parameter int OPW = 2
) (
    input  logic [OPW-1:0]   op,
    input  logic [UPC_W-1:0] pc,
    output uop_t             uop
);
    localparam int NUM_OPS  = 1 << OPW;
    localparam int PROG_LEN = 1 << UPC_W;

    // Program text: loop body starts at micro-op 0 for every opcode.
    function automatic uop_t prog_word(int opc, int addr);
        uop_t u;
        u = mk_uop(UOP_DONE, RS_ZERO, RS_ZERO, '0);
        case (opc)
            0: case (addr)
                0: u = mk_uop(UOP_AAP,  RS_SRC1, RS_DST, '0);
                1: u = mk_uop(UOP_LOOP, RS_ZERO, RS_ZERO, '0);
                default: ;
            endcase
            1: case (addr)
                0: u = mk_uop(UOP_AAP,  RS_SRC1,   RS_T0,  '0);
                1: u = mk_uop(UOP_AAP,  RS_SRC2,   RS_T1,  '0);
                2: u = mk_uop(UOP_AAP,  RS_ZERO,   RS_T2,  '0);
                3: u = mk_uop(UOP_AAP,  RS_TRIPLE, RS_DST, '0);
                4: u = mk_uop(UOP_LOOP, RS_ZERO,   RS_ZERO, '0);
                default: ;
            endcase
            2: case (addr)
                0: u = mk_uop(UOP_AAP,  RS_SRC1,   RS_T0,  '0);
                1: u = mk_uop(UOP_AAP,  RS_SRC2,   RS_T1,  '0);
                2: u = mk_uop(UOP_AAP,  RS_DST,    RS_T2,  '0);
                3: u = mk_uop(UOP_AP,   RS_TRIPLE, RS_ZERO, '0);
                4: u = mk_uop(UOP_AAP,  RS_T0,     RS_DST, '0);
                5: u = mk_uop(UOP_LOOP, RS_ZERO,   RS_ZERO, '0);
                default: ;
            endcase
            3: case (addr)
                0: u = mk_uop(UOP_AAP,  RS_ZERO, RS_DST, '0);
                1: u = mk_uop(UOP_LOOP, RS_ZERO, RS_ZERO, '0);
                default: ;
            endcase
            default: ;
        endcase
        return u;
    endfunction

    uop_t table_q [NUM_OPS * PROG_LEN];

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        for (genvar a = 0; a < PROG_LEN; a++) begin : g_addr
            assign table_q[o * PROG_LEN + a] = prog_word(o, a);
        end
    end

    assign uop = table_q[{op, pc}];
endmodule

// File: rtl/bsq_engine.sv
module bsq_engine
    import bsq_pkg::*;
#(
    parameter int ROWW      = 10,
    parameter int NW        = 5,
    parameter int TROW_BASE = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic [ROWW-1:0]  head_dst,
    input  logic [ROWW-1:0]  head_src1,
    input  logic [ROWW-1:0]  head_src2,
    input  logic [NW-1:0]    head_n,
    input  uop_t             uop,
    output logic [UPC_W-1:0] pc,
    output logic             pop,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic             cmd_kind,
    output logic [ROWW-1:0]  cmd_row,
    output logic             op_done
);
    localparam logic [ROWW-1:0] T_BASE = ROWW'(TROW_BASE);

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_ACT_A, ST_ACT_B, ST_PRE, ST_RETIRE
    } seq_state_e;

    seq_state_e       state_q;
    logic [UPC_W-1:0] pc_q;
    logic [NW-1:0]    idx_q;
    logic [NW-1:0]    cnt_q;

    function automatic logic [ROWW-1:0] resolve(row_sel_e s, logic [NW-1:0] i);
        logic [ROWW-1:0] off;
        off = ROWW'(i);
        case (s)
            RS_SRC1:   return head_src1 + off;
            RS_SRC2:   return head_src2 + off;
            RS_DST:    return head_dst + off;
            RS_T0:     return T_BASE;
            RS_T1:     return T_BASE + ROWW'(1);
            RS_T2:     return T_BASE + ROWW'(2);
            RS_TRIPLE: return T_BASE + ROWW'(3);
            default:   return T_BASE + ROWW'(4);
        endcase
    endfunction

    // State register and sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (head_valid) begin
                        if (head_n == '0) begin
                            state_q <= ST_RETIRE;
                        end else begin
                            cnt_q   <= head_n;
                            idx_q   <= '0;
                            pc_q    <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    unique case (uop.kind)
                        UOP_AAP, UOP_AP: state_q <= ST_ACT_A;
                        UOP_LOOP: begin
                            cnt_q <= cnt_q - 1'b1;
                            if (cnt_q != NW'(1)) begin
                                pc_q  <= uop.target;
                                idx_q <= idx_q + 1'b1;
                            end else begin
                                pc_q  <= pc_q + 1'b1;
                            end
                        end
                        UOP_DONE: state_q <= ST_RETIRE;
                    endcase
                end
                ST_ACT_A: begin
                    if (cmd_ready)
                        state_q <= (uop.kind == UOP_AAP) ? ST_ACT_B : ST_PRE;
                end
                ST_ACT_B: begin
                    if (cmd_ready) state_q <= ST_PRE;
                end
                ST_PRE: begin
                    if (cmd_ready) begin
                        pc_q    <= pc_q + 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                ST_RETIRE: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        cmd_valid = 1'b0;
        cmd_kind  = CMD_ACT;
        cmd_row   = '0;
        pop       = 1'b0;
        op_done   = 1'b0;
        unique case (state_q)
            ST_ACT_A: begin
                cmd_valid = 1'b1;
                cmd_row   = resolve(uop.sel_a, idx_q);
            end
            ST_ACT_B: begin
                cmd_valid = 1'b1;
                cmd_row   = resolve(uop.sel_b, idx_q);
            end
            ST_PRE: begin
                cmd_valid = 1'b1;
                cmd_kind  = CMD_PRE;
            end
            ST_RETIRE: begin
                pop     = 1'b1;
                op_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign pc = pc_q;
endmodule

// File: rtl/bitserial_seq.sv
module bitserial_seq
    import bsq_pkg::*;
#(
    parameter int OPW       = 2,
    parameter int ROWW      = 10,
    parameter int NW        = 5,
    parameter int DEPTH     = 4,
    parameter int TROW_BASE = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [OPW-1:0]  in_op,
    input  logic [ROWW-1:0] in_dst,
    input  logic [ROWW-1:0] in_src1,
    input  logic [ROWW-1:0] in_src2,
    input  logic [NW-1:0]   in_n,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    output logic            cmd_kind,
    output logic [ROWW-1:0] cmd_row,
    output logic            op_done
);
    localparam int IW = OPW + 3 * ROWW + NW;

    logic [IW-1:0]    head;
    logic             q_full, q_empty, q_pop;
    logic [OPW-1:0]   h_op;
    logic [ROWW-1:0]  h_dst, h_src1, h_src2;
    logic [NW-1:0]    h_n;
    logic [UPC_W-1:0] upc;
    uop_t             cur_uop;

    assign in_ready = !q_full;
    assign {h_op, h_dst, h_src1, h_src2, h_n} = head;

    bsq_fifo #(.W(IW), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .din   ({in_op, in_dst, in_src1, in_src2, in_n}),
        .pop   (q_pop),
        .dout  (head),
        .full  (q_full),
        .empty (q_empty)
    );

    bsq_uprog_rom #(.OPW(OPW)) u_rom (
        .op  (h_op),
        .pc  (upc),
        .uop (cur_uop)
    );

    bsq_engine #(.ROWW(ROWW), .NW(NW), .TROW_BASE(TROW_BASE)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!q_empty),
        .head_dst   (h_dst),
        .head_src1  (h_src1),
        .head_src2  (h_src2),
        .head_n     (h_n),
        .uop        (cur_uop),
        .pc         (upc),
        .pop        (q_pop),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_kind   (cmd_kind),
        .cmd_row    (cmd_row),
        .op_done    (op_done)
    );
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
    parameter int ROWW  = 10,
    parameter int DEPTH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            cmd_kind,
    input logic [ROWW-1:0] cmd_row,
    input logic            op_done
);
    localparam int OCW = $clog2(DEPTH + 1) + 1;

    logic [OCW-1:0] occ_q;
    logic [1:0]     act_run_q;
    logic           acc;

    assign acc = cmd_valid && cmd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q     <= '0;
            act_run_q <= '0;
        end else begin
            occ_q <= occ_q + OCW'(in_valid && in_ready) - OCW'(op_done);
            if (acc) act_run_q <= cmd_kind ? 2'd0 : act_run_q + 2'd1;
        end
    end

    // R1: room is offered exactly while fewer than DEPTH instructions are pending
    p_ready_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (occ_q < OCW'(DEPTH)));
    p_ready_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (occ_q == OCW'(DEPTH)));

    // R2: a PRE is only taken after at least one ACT
    p_pre_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_kind) |-> (act_run_q != 2'd0));

    // R3: never a third ACT before a PRE
    p_act_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cmd_kind) |-> (act_run_q < 2'd2));

    // R8: a stalled command holds
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_row)));

    // R9: retirement pulse is single-cycle and never overlaps a command
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !cmd_valid);
    p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (act_run_q == 2'd0));
endmodule

bind bitserial_seq bsq_checker #(.ROWW(ROWW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_row   (cmd_row),
    .op_done   (op_done)
);

// File: tb/bitserial_seq_tb.sv
`timescale 1ns/1ps
module bitserial_seq_tb;
    localparam int OPW = 2, ROWW = 10, NW = 5, DEPTH = 4, TB = 1000;
    localparam int MAXE = 4096;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, cmd_ready = 1'b0;
    logic [OPW-1:0] in_op = '0;
    logic [ROWW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [NW-1:0] in_n = '0;
    logic in_ready, cmd_valid, cmd_kind, op_done;
    logic [ROWW-1:0] cmd_row;

    always #2.5 clk = ~clk;

    bitserial_seq #(.OPW(OPW), .ROWW(ROWW), .NW(NW), .DEPTH(DEPTH), .TROW_BASE(TB)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_n(in_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_row(cmd_row), .op_done(op_done));

    int total = 0, bad = 0;
    logic            exp_kind [MAXE];
    logic [ROWW-1:0] exp_row  [MAXE];
    int exp_end [256];
    int wr = 0, rd = 0, pushed = 0, dones = 0;
    int ready_mode = 0;
    bit saw_valid = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_cmd(logic k, logic [ROWW-1:0] r);
        exp_kind[wr] = k;
        exp_row[wr]  = r;
        wr++;
    endtask

    task automatic aap(logic [ROWW-1:0] a, logic [ROWW-1:0] b);
        add_cmd(1'b0, a); add_cmd(1'b0, b); add_cmd(1'b1, '0);
    endtask

    // R6 programs with R4 row arithmetic
    task automatic model(int op, int d, int s1, int s2, int n);
        logic [ROWW-1:0] t0, t1, t2, tri_r, zr, di, ai, bi;
        t0 = ROWW'(TB); t1 = ROWW'(TB + 1); t2 = ROWW'(TB + 2);
        tri_r = ROWW'(TB + 3); zr = ROWW'(TB + 4);
        for (int i = 0; i < n; i++) begin
            di = ROWW'(d + i); ai = ROWW'(s1 + i); bi = ROWW'(s2 + i);
            case (op)
                0: aap(ai, di);
                1: begin aap(ai, t0); aap(bi, t1); aap(zr, t2); aap(tri_r, di); end
                2: begin
                    aap(ai, t0); aap(bi, t1); aap(di, t2);
                    add_cmd(1'b0, tri_r); add_cmd(1'b1, '0);
                    aap(t0, di);
                end
                default: aap(zr, di);
            endcase
        end
    endtask

    task automatic push(int op, int d, int s1, int s2, int n);
        model(op, d, s1, s2, n);
        exp_end[pushed] = wr;
        pushed++;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_op = OPW'(op); in_dst = ROWW'(d);
        in_src1 = ROWW'(s1); in_src2 = ROWW'(s2); in_n = NW'(n);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (dones != pushed && guard < 20000) begin
            @(negedge clk); guard++;
        end
        check(dones == pushed, "R5 all retired", dones, pushed);
        check(rd == wr, "R5 all commands issued", rd, wr);
    endtask

    // ready driver, updated just after each rising edge
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0: cmd_ready = 1'b1;
            1: cmd_ready = lfsr[0] | lfsr[3];
            default: cmd_ready = 1'b0;
        endcase
    end

    // monitor on falling edges
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (cmd_valid) saw_valid = 1;
            if (cmd_valid && cmd_ready) begin
                if (rd < wr) begin
                    check(cmd_kind == exp_kind[rd], "R2 R3 R6 command kind", cmd_kind, exp_kind[rd]);
                    check(cmd_row == exp_row[rd], "R4 R6 command row", cmd_row, exp_row[rd]);
                end else begin
                    check(0, "R5 extra command", rd, wr);
                end
                rd++;
            end
            if (op_done) begin
                check(rd == exp_end[dones], "R9 done after last command", rd, exp_end[dones]);
                dones++;
            end
        end
    end

    initial begin
        #(5ns * 150000);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n_set [5] = '{0, 1, 2, 3, 7};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cmd_valid == 0, "R10 cmd_valid reset", cmd_valid, 0);
        check(op_done == 0, "R10 op_done reset", op_done, 0);
        check(in_ready == 1, "R10 in_ready reset", in_ready, 1);

        // R8 and R1: stall with a full queue
        ready_mode = 2;
        for (int k = 0; k < DEPTH; k++) push(0, 100 + k, 200 + k, 300, 1);
        @(negedge clk);
        check(in_ready == 0, "R1 queue full", in_ready, 0);
        check(cmd_valid == 1 && cmd_kind == 0, "R8 stalled ACT", cmd_kind, 0);
        check(cmd_row == ROWW'(200), "R8 stalled row", cmd_row, 200);
        repeat (3) @(negedge clk);
        check(cmd_valid == 1 && cmd_row == ROWW'(200), "R8 held row", cmd_row, 200);
        ready_mode = 0;
        drain();

        // R7: zero width issues nothing
        ready_mode = 2;
        saw_valid = 0;
        push(1, 10, 20, 30, 0);
        repeat (6) @(negedge clk);
        check(dones == pushed, "R7 zero-width retired", dones, pushed);
        check(saw_valid == 0, "R7 no command", saw_valid, 0);
        ready_mode = 0;

        // Sweep: opcodes x widths x ready patterns (R5 R6 R1 ordering)
        for (int m = 0; m < 2; m++) begin
            ready_mode = m;
            for (int op = 0; op < 4; op++)
                for (int j = 0; j < 5; j++)
                    push(op, 40 * op + j, 500 + 7 * j, 700 + 3 * op, n_set[j]);
            drain();
        end

        // R4: address wrap modulo 2^ROWW
        ready_mode = 1;
        push(2, 1021, 1022, 1023, 3);
        push(0, 1023, 1020, 0, 5);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule